// File: doc/BRIEF.md
# Block-Locked Bus Arbiter for Eight DMA Channels

This block decides which of eight DMA channels owns a shared memory bus. A channel raises its request line whenever it is enabled and has a block waiting. When the bus is free and arbitration is enabled, the arbiter picks one requester and gives it a registered one-hot grant. The policy is chosen at runtime by a mode input: fixed priority or round robin.

A granted channel keeps the bus for one whole block. The block length is a power of two, 2^x words. The arbiter reads the 4-bit exponent x from the winning channel's field at the moment of the grant. It counts accepted bus beats and drops the grant after the last word of the block. It never preempts a block. Address generation and data movement stay inside the channels.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `gnt` is all zeros and `busy` is 0.
- R2: `gnt` is always zero or one-hot. It only ever points at a channel whose `req` bit was high in the cycle in which the bus was idle. The grant appears on the clock edge that follows that idle cycle.
- R3: When `rr_mode` is 0, the requesting channel with the lowest index wins. Channel 0 has the highest priority.
- R4: When `rr_mode` is 1, the search starts at the channel after the last one granted and wraps from 7 to 0. After reset the search starts at channel 0.
- R5: `rr_mode` is sampled at each arbitration decision. A change takes effect at the next decision and does not disturb a block in progress. The round-robin history is kept while fixed mode is in use.
- R6: Once granted, a channel keeps the grant for exactly 2^x cycles with `beat` high. Here x is bits [4i+3:4i] of `blk_log2` for channel i, sampled at the grant. Changes to that field during the block have no effect, and neither does dropping `req`.
- R7: The grant clears on the edge that registers the final beat. The bus stays idle for one cycle, and a new grant can appear on the following edge.
- R8: While `arb_en` is 0, no new grant is issued. A block already granted still runs to its final beat.
- R9: `beat` has no effect while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arb_en | input | 1 | Master enable for new grants |
| rr_mode | input | 1 | 0 = fixed priority, 1 = round robin |
| req | input | 8 | Per-channel request |
| blk_log2 | input | 32 | Per-channel block size exponent, 4 bits each, channel i at [4i+3:4i] |
| beat | input | 1 | One word of the current block accepted by the bus |
| gnt | output | 8 | Registered one-hot grant |
| busy | output | 1 | Bus owned by a channel |

## Verification
The bench targets several corner cases, and each one exposes a distinct fault:

- **Size-0 blocks.** A design whose beat counter is off by one would hold the bus for two beats instead of one.
- **Exponent change mid-block.** A design that reads the exponent live instead of latching it would end the block early or late.
- **Enable dropped mid-block.** A design that gates the lock with the enable would cut the block short.
- **Round-robin wraparound, and switching policy while all channels request.** A design with a stuck or wrongly started pointer would hand the bus to the wrong channel.

Random request, beat and enable patterns also check that a stray beat on an idle bus is ignored and that the idle gap between blocks is exactly one cycle.

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int NCH = 8,
  parameter int SZW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arb_en,
  input  logic                 rr_mode,
  input  logic [NCH-1:0]       req,
  input  logic [NCH*SZW-1:0]   blk_log2,
  input  logic                 beat,
  output logic [NCH-1:0]       gnt,
  output logic                 busy
);
  localparam int IW = $clog2(NCH);
  localparam int CW = 2**SZW;

  logic [IW-1:0]  last, pick;
  logic           found;
  logic [SZW-1:0] sz;
  logic [CW-1:0]  cnt, limit;

  assign busy  = |gnt;
  assign limit = (CW'(1) << sz) - CW'(1);

  always_comb begin
    int j;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NCH; k++) begin
      j = rr_mode ? (int'(last) + 1 + k) % NCH : k;
      if (!found && req[j]) begin
        found = 1'b1;
        pick  = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt  <= '0;
      last <= IW'(NCH - 1);
      sz   <= '0;
      cnt  <= '0;
    end else if (busy) begin
      if (beat) begin
        if (cnt == limit) gnt <= '0;
        else              cnt <= cnt + CW'(1);
      end
    end else if (arb_en && found) begin
      gnt  <= NCH'(1) << pick;
      last <= pick;
      sz   <= blk_log2[pick*SZW +: SZW];
      cnt  <= '0;
    end
  end
endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
  parameter int NCH = 8,
  parameter int SZW = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arb_en,
  input logic               rr_mode,
  input logic [NCH-1:0]     req,
  input logic [NCH*SZW-1:0] blk_log2,
  input logic               beat,
  input logic [NCH-1:0]     gnt,
  input logic               busy
);
  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R2
  gnt_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (gnt == '0 || (gnt & $past(req)) != '0));
  // R3
  fixed_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && arb_en && !rr_mode && |req) |=>
      gnt == ($past(req) & (~$past(req) + NCH'(1))));
  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !beat) |=> $stable(gnt));
  // R7
  release_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || $past(beat)));
  // R8
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !arb_en) |=> !busy);
  // R9
  idle_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(arb_en && |req)) |=> !busy);
endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.NCH(NCH), .SZW(SZW)) chk_i (.*);

// File: tb/dma_bus_arbiter_test.sv
module dma_bus_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n, arb_en, rr_mode, beat;
  logic [7:0]  req;
  logic [31:0] blk_log2;
  logic [7:0]  gnt;
  logic        busy;

  int checks = 0, errors = 0;
  logic [7:0] mg;
  int mlast, mcnt, mlen;
  bit done = 0;

  always #5 clk = ~clk;

  dma_bus_arbiter uut (.clk(clk), .rst_n(rst_n), .arb_en(arb_en), .rr_mode(rr_mode),
    .req(req), .blk_log2(blk_log2), .beat(beat), .gnt(gnt), .busy(busy));

  function automatic int pick_f(logic [7:0] r, logic rrm, int lst);
    for (int k = 0; k < 8; k++) begin
      int j = rrm ? (lst + 1 + k) % 8 : k;
      if (r[j]) return j;
    end
    return -1;
  endfunction

  task automatic check(string tag);
    checks++;
    if (gnt !== mg || busy !== (mg != 0)) begin
      errors++;
      $display("FAIL %s gnt=%b busy=%b expected gnt=%b busy=%b", tag, gnt, busy, mg, mg != 0);
    end
  endtask

  task automatic step(string tag);
    if (mg != 0) begin
      if (beat) begin
        if (mcnt == mlen - 1) mg = 0;
        else mcnt++;
      end
    end else if (arb_en) begin
      int p = pick_f(req, rr_mode, mlast);
      if (p >= 0) begin
        mg = 8'(1) << p; mlast = p; mcnt = 0;
        mlen = 1 << blk_log2[p*4 +: 4];
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; arb_en = 1; rr_mode = 0; beat = 1; req = 8'hff; blk_log2 = '0;
    mg = 0; mlast = 7; mcnt = 0; mlen = 1;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1; req = 0; arb_en = 0;
    step("R1 after reset");
    // R9 beats on idle bus
    beat = 1; arb_en = 1;
    repeat (4) step("R9");
    // R8 enable low blocks grants
    arb_en = 0; req = 8'hff;
    repeat (4) step("R8 no grant");
    // R8 enable dropped mid-block, block of 4 beats completes
    blk_log2 = {8{4'd2}}; arb_en = 1; beat = 0;
    step("R8 grant");
    arb_en = 0;
    repeat (3) step("R8 hold");
    beat = 1;
    repeat (6) step("R8 finish");
    // R3 fixed priority, size-0 blocks, R7 idle gap
    arb_en = 1; blk_log2 = '0; req = 8'b1011_0100;
    repeat (8) step("R3 R7");
    // R4 round robin with all requesting, wraps
    rr_mode = 1; req = 8'hff;
    repeat (24) step("R4");
    // R5 switch policy in flight
    req = 8'b0110_0001;
    repeat (3) step("R5 rr");
    rr_mode = 0;
    repeat (4) step("R5 fixed");
    rr_mode = 1;
    repeat (4) step("R5 back");
    // R6 exponent change and request drop mid-block
    blk_log2 = {8{4'd3}}; req = 8'h01; rr_mode = 0; beat = 0;
    step("R6 grant");
    blk_log2 = '0; req = 0; beat = 1;
    repeat (10) step("R6 latched size");
    // R6 largest-ish exponent on one channel
    blk_log2 = 32'h0000_0007; req = 8'h01;
    step("R6 big grant");
    req = 0;
    repeat (130) step("R6 big");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (i % 200 == 0) rr_mode = 1'($urandom_range(0, 1));
      req    = 8'($urandom);
      beat   = ($urandom_range(0, 9) < 7);
      arb_en = ($urandom_range(0, 9) < 8);
      for (int c = 0; c < 8; c++) blk_log2[c*4 +: 4] = 4'($urandom_range(0, 3));
      step("R2 R6 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule